// File: doc/BRIEF.md
# NAND Page Hamming ECC Engine

This block watches the byte-wide command, address and data traffic of a NAND flash bus. While a page's main area goes by, it builds a single-error-correcting, double-error-detecting Hamming code. The code is a pair of words, a parity word and an inverse-parity word. Each word holds one bit per bit of the position index, where the position of a data bit is its byte offset times eight plus its bit index. Parity bit k is the XOR of every data bit whose position has bit k set. Inverse-parity bit k is the XOR of every data bit whose position has bit k clear.

The command bytes themselves arm the engine.
- A program command (80h) clears the code, and accumulation begins once the address cycles are done.
- A read command (00h) clears the code, and accumulation begins only after the address cycles and the read-confirm command (30h).

On a read, the bytes that follow the main area carry the stored code. The engine compares the stored code with the recomputed one and reports one of four outcomes: clean, correctable data error (with the byte offset and bit index of the bad bit), error inside the stored code, or multiple errors. Fixing the data is left to the consumer.

Top module: `nand_page_ecc`

## Requirements
- R1: After reset, both code words, the done flag, all four outcome flags, the error byte offset and the error bit index are zero.
- R2: A command byte 80h clears both code words, the done flag and the outcome flags. Data beats are then ignored until ADDR_CYCLES address strobes have been seen; after that, data beats accumulate.
- R3: A command byte 00h clears the same state as R2. Data beats are ignored until ADDR_CYCLES address strobes have been seen and then a command byte 30h has been seen.
- R4: After MAIN_BYTES accumulated beats, for every k, parity bit k equals the XOR of all data bits whose position (byte offset*8 + bit index, bit index 0 = LSB) has bit k = 1. Inverse-parity bit k equals the XOR of the data bits whose position has bit k = 0. Each word is PW = log2(MAIN_BYTES)+3 bits wide.
- R5: After a program's main area, further data beats and command bytes other than 80h and 00h leave both code words unchanged.
- R6: On a read, the CODE_BYTES beats after the main area are the stored code, least significant byte first. Bits [PW-1:0] hold the parity word, bits [2*PW-1:PW] hold the inverse-parity word, and any bits above 2*PW-1 are ignored. After the last of these bytes, done is set.
- R7: If the stored code equals the recomputed one, only the ok flag is set. At most one outcome flag is ever set.
- R8: If every parity/inverse-parity bit pair of the syndrome (stored XOR computed) differs in exactly one bit, only the correctable flag is set. The error byte offset and bit index then equal the position held in the parity half of the syndrome.
- R9: If exactly one syndrome bit is set, only the code-error flag is set.
- R10: Any other nonzero syndrome sets only the multiple-error flag.
- R11: If a command byte 80h or 00h arrives in the cycle in which a result would be published, the clear wins: done and all flags stay zero.
- R12: Once published, done, the flags and the error location hold unchanged until the next 80h or 00h command, whatever other bus traffic follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_stb | input | 1 | Command byte on bus_byte this cycle |
| addr_stb | input | 1 | Address byte on bus_byte this cycle |
| data_stb | input | 1 | Data beat on bus_byte this cycle |
| bus_byte | input | 8 | Flash bus byte |
| par_o | output | PW | Parity word |
| npar_o | output | PW | Inverse-parity word |
| done_o | output | 1 | Read check result published |
| ok_o | output | 1 | No error |
| corr_o | output | 1 | Single correctable data-bit error |
| code_err_o | output | 1 | Error inside the stored code |
| multi_o | output | 1 | Uncorrectable multiple error |
| err_byte_o | output | PW-3 | Byte offset of the correctable error |
| err_bit_o | output | 3 | Bit index of the correctable error |

## Verification
Two actions can fall on the same clock edge. One is publishing a classification, which is registered one cycle after the last stored-code byte. The other is a clearing read command that starts a new page. The bench provokes this by driving the last stored-code byte and then, in the very next cycle, a 00h command, so that both reach the result registers on the same edge. It then expects done and every outcome flag to be zero, and the code words cleared, as if no result had been computed.

// File: rtl/nand_ecc_pkg.sv
package nand_ecc_pkg;

  localparam logic [7:0] CMD_PROG = 8'h80;
  localparam logic [7:0] CMD_READ = 8'h00;
  localparam logic [7:0] CMD_CONF = 8'h30;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_CONF,
    ST_ACC,
    ST_CODE,
    ST_DONE
  } ecc_state_t;

  typedef struct packed {
    logic ok;
    logic corr;
    logic code_err;
    logic multi;
  } ecc_flags_t;

endpackage

// File: rtl/ecc_seq.sv
module ecc_seq
  import nand_ecc_pkg::*;
#(
  parameter int MAIN_BYTES  = 256,
  parameter int ADDR_CYCLES = 5,
  parameter int CODE_BYTES  = 3,
  localparam int AW  = $clog2(MAIN_BYTES),
  localparam int ACW = $clog2(ADDR_CYCLES + 1),
  localparam int CIW = (CODE_BYTES > 1) ? $clog2(CODE_BYTES) : 1
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           cmd_stb,
  input  logic           addr_stb,
  input  logic           data_stb,
  input  logic [7:0]     bus_byte,
  output logic           clr,
  output logic           acc_en,
  output logic [AW-1:0]  byte_idx,
  output logic           code_en,
  output logic [CIW-1:0] code_idx,
  output logic           check
);

  ecc_state_t     state;
  logic           is_rd;
  logic [ACW-1:0] acnt;
  logic [AW-1:0]  bcnt;
  logic [CIW-1:0] ccnt;

  assign clr      = cmd_stb && (bus_byte == CMD_PROG || bus_byte == CMD_READ);
  assign acc_en   = (state == ST_ACC) && data_stb && !clr;
  assign code_en  = (state == ST_CODE) && data_stb && !clr;
  assign byte_idx = bcnt;
  assign code_idx = ccnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= ST_IDLE;
      is_rd <= 1'b0;
      acnt  <= '0;
      bcnt  <= '0;
      ccnt  <= '0;
      check <= 1'b0;
    end else begin
      check <= 1'b0;
      if (clr) begin
        state <= ST_ADDR;
        is_rd <= (bus_byte == CMD_READ);
        acnt  <= '0;
        bcnt  <= '0;
        ccnt  <= '0;
      end else begin
        case (state)
          ST_ADDR: if (addr_stb) begin
            if (acnt == ACW'(ADDR_CYCLES - 1)) state <= is_rd ? ST_CONF : ST_ACC;
            else acnt <= acnt + 1'b1;
          end
          ST_CONF: if (cmd_stb && bus_byte == CMD_CONF) state <= ST_ACC;
          ST_ACC: if (data_stb) begin
            if (bcnt == AW'(MAIN_BYTES - 1)) begin
              state <= is_rd ? ST_CODE : ST_DONE;
              bcnt  <= '0;
            end else begin
              bcnt <= bcnt + 1'b1;
            end
          end
          ST_CODE: if (data_stb) begin
            if (ccnt == CIW'(CODE_BYTES - 1)) begin
              state <= ST_DONE;
              check <= 1'b1;
            end else begin
              ccnt <= ccnt + 1'b1;
            end
          end
          default: ;
        endcase
      end
    end
  end

  // R2 / R3: accumulation is entered only right after an address or command strobe
  a_r3_enter_acc: assert property (@(posedge clk) disable iff (rst)
    (state == ST_ACC && $past(state) != ST_ACC) |-> $past(cmd_stb || addr_stb));

endmodule

// File: rtl/ecc_accum.sv
module ecc_accum #(
  parameter int AW = 8,
  localparam int PW = AW + 3
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clr,
  input  logic          acc_en,
  input  logic [AW-1:0] byte_idx,
  input  logic [7:0]    data,
  output logic [PW-1:0] par,
  output logic [PW-1:0] npar
);

  logic [PW-1:0] par_c, npar_c;
  logic          row_x;

  assign row_x = ^data;

  // bit-index part of the position: fold the byte by bit-number masks
  for (genvar k = 0; k < 3; k++) begin : g_col
    logic [7:0] m1;
    for (genvar b = 0; b < 8; b++) begin : g_m
      assign m1[b] = ((b >> k) & 1) == 1;
    end
    assign par_c[k]  = ^(data & m1);
    assign npar_c[k] = ^(data & ~m1);
  end

  // byte-offset part of the position: whole-byte parity steered by offset bit
  for (genvar k = 3; k < PW; k++) begin : g_row
    assign par_c[k]  = byte_idx[k-3] ? row_x : 1'b0;
    assign npar_c[k] = byte_idx[k-3] ? 1'b0 : row_x;
  end

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      par  <= '0;
      npar <= '0;
    end else if (acc_en) begin
      par  <= par ^ par_c;
      npar <= npar ^ npar_c;
    end
  end

  a_r5_code_frozen: assert property (@(posedge clk) disable iff (rst)
    (!acc_en && !clr) |=> ($stable(par) && $stable(npar)));

endmodule

// File: rtl/ecc_classify.sv
module ecc_classify
  import nand_ecc_pkg::*;
#(
  parameter int AW = 8,
  parameter int CODE_BYTES = 3,
  localparam int PW = AW + 3,
  localparam int CW = 2 * PW,
  localparam int CIW = (CODE_BYTES > 1) ? $clog2(CODE_BYTES) : 1
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           clr,
  input  logic           code_en,
  input  logic [CIW-1:0] code_idx,
  input  logic [7:0]     data,
  input  logic           check,
  input  logic [PW-1:0]  par,
  input  logic [PW-1:0]  npar,
  output logic           done,
  output ecc_flags_t     flags,
  output logic [AW-1:0]  err_byte,
  output logic [2:0]     err_bit
);

  logic [CW-1:0] stored;
  logic [CW-1:0] syn;
  logic [PW-1:0] syn_p, syn_n;
  logic          syn_zero, syn_single, pairs_split;

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      stored <= '0;
    end else if (code_en) begin
      for (int j = 0; j < CODE_BYTES; j++) begin
        if (code_idx == CIW'(j)) begin
          for (int b = 0; b < 8; b++) begin
            if (j * 8 + b < CW) stored[j*8+b] <= data[b];
          end
        end
      end
    end
  end

  assign syn         = stored ^ {npar, par};
  assign syn_p       = syn[PW-1:0];
  assign syn_n       = syn[CW-1:PW];
  assign syn_zero    = (syn == '0);
  assign syn_single  = !syn_zero && ((syn & (syn - 1'b1)) == '0);
  assign pairs_split = &(syn_p ^ syn_n);

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      done     <= 1'b0;
      flags    <= '0;
      err_byte <= '0;
      err_bit  <= '0;
    end else if (check) begin
      done           <= 1'b1;
      flags.ok       <= syn_zero;
      flags.code_err <= syn_single;
      flags.corr     <= pairs_split;
      flags.multi    <= !syn_zero && !syn_single && !pairs_split;
      err_byte       <= pairs_split ? syn_p[PW-1:3] : '0;
      err_bit        <= pairs_split ? syn_p[2:0] : '0;
    end
  end

  a_r7_one_outcome: assert property (@(posedge clk) disable iff (rst)
    $onehot0(flags));

  a_r7_done_has_outcome: assert property (@(posedge clk) disable iff (rst)
    done |-> (flags != '0));

  a_r11_clear_wins: assert property (@(posedge clk) disable iff (rst)
    clr |=> (!done && flags == '0));

  a_r12_result_hold: assert property (@(posedge clk) disable iff (rst)
    (done && !clr) |=> (done && $stable(flags) && $stable(err_byte) && $stable(err_bit)));

endmodule

// File: rtl/nand_page_ecc.sv
module nand_page_ecc
  import nand_ecc_pkg::*;
#(
  parameter int MAIN_BYTES  = 256,
  parameter int ADDR_CYCLES = 5,
  localparam int AW  = $clog2(MAIN_BYTES),
  localparam int PW  = AW + 3,
  localparam int CB  = (2 * PW + 7) / 8,
  localparam int CIW = (CB > 1) ? $clog2(CB) : 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cmd_stb,
  input  logic          addr_stb,
  input  logic          data_stb,
  input  logic [7:0]    bus_byte,
  output logic [PW-1:0] par_o,
  output logic [PW-1:0] npar_o,
  output logic          done_o,
  output logic          ok_o,
  output logic          corr_o,
  output logic          code_err_o,
  output logic          multi_o,
  output logic [AW-1:0] err_byte_o,
  output logic [2:0]    err_bit_o
);

  logic           clr, acc_en, code_en, check;
  logic [AW-1:0]  byte_idx;
  logic [CIW-1:0] code_idx;
  ecc_flags_t     flags;

  ecc_seq #(.MAIN_BYTES(MAIN_BYTES), .ADDR_CYCLES(ADDR_CYCLES), .CODE_BYTES(CB)) u_seq (
    .clk(clk), .rst(rst), .cmd_stb(cmd_stb), .addr_stb(addr_stb), .data_stb(data_stb),
    .bus_byte(bus_byte), .clr(clr), .acc_en(acc_en), .byte_idx(byte_idx),
    .code_en(code_en), .code_idx(code_idx), .check(check)
  );

  ecc_accum #(.AW(AW)) u_acc (
    .clk(clk), .rst(rst), .clr(clr), .acc_en(acc_en), .byte_idx(byte_idx),
    .data(bus_byte), .par(par_o), .npar(npar_o)
  );

  ecc_classify #(.AW(AW), .CODE_BYTES(CB)) u_cls (
    .clk(clk), .rst(rst), .clr(clr), .code_en(code_en), .code_idx(code_idx),
    .data(bus_byte), .check(check), .par(par_o), .npar(npar_o),
    .done(done_o), .flags(flags), .err_byte(err_byte_o), .err_bit(err_bit_o)
  );

  assign ok_o       = flags.ok;
  assign corr_o     = flags.corr;
  assign code_err_o = flags.code_err;
  assign multi_o    = flags.multi;

endmodule

// File: tb/tb_nand_page_ecc.sv
module tb_nand_page_ecc;
  localparam int MAIN = 256, ADDRC = 5, AW = 8, PW = 11, CB = 3;

  logic clk = 1'b0, rst = 1'b1;
  logic cmd_stb = 0, addr_stb = 0, data_stb = 0;
  logic [7:0] bus_byte = 0;
  logic [PW-1:0] par_o, npar_o;
  logic done_o, ok_o, corr_o, code_err_o, multi_o;
  logic [AW-1:0] err_byte_o;
  logic [2:0] err_bit_o;

  always #2 clk = ~clk;

  nand_page_ecc #(.MAIN_BYTES(MAIN), .ADDR_CYCLES(ADDRC)) dut (.*);

  typedef struct packed {
    logic [PW-1:0] par;
    logic [PW-1:0] npar;
    logic          done;
    logic [3:0]    fl;
    logic [AW-1:0] eb;
    logic [2:0]    ebit;
  } exp_t;

  exp_t  q[$];
  string tq[$];
  event  smp;
  int    checks = 0, errors = 0;
  logic [7:0] pg [MAIN];

  // scoreboard monitor
  initial forever begin
    @(smp);
    while (q.size() > 0) begin
      exp_t e;
      string t;
      e = q.pop_front();
      t = tq.pop_front();
      checks++;
      if (par_o !== e.par || npar_o !== e.npar) begin
        errors++;
        $display("FAIL %s code: par=%h npar=%h expected par=%h npar=%h", t, par_o, npar_o, e.par, e.npar);
      end
      checks++;
      if ({done_o, ok_o, corr_o, code_err_o, multi_o, err_byte_o, err_bit_o} !==
          {e.done, e.fl, e.eb, e.ebit}) begin
        errors++;
        $display("FAIL %s result: done=%b flags=%b byte=%0d bit=%0d expected done=%b flags=%b byte=%0d bit=%0d",
                 t, done_o, {ok_o, corr_o, code_err_o, multi_o}, err_byte_o, err_bit_o,
                 e.done, e.fl, e.eb, e.ebit);
      end
    end
  end

  task automatic expect_now(input string t, input logic [2*PW-1:0] code, input logic dn,
                            input logic [3:0] fl, input logic [AW-1:0] eb, input logic [2:0] eb2);
    exp_t e;
    e.par = code[PW-1:0]; e.npar = code[2*PW-1:PW];
    e.done = dn; e.fl = fl; e.eb = eb; e.ebit = eb2;
    q.push_back(e); tq.push_back(t);
    ->smp;
    #1;
  endtask

  function automatic logic [2*PW-1:0] model();
    logic [PW-1:0] p, n;
    p = '0; n = '0;
    for (int i = 0; i < MAIN; i++) begin
      for (int b = 0; b < 8; b++) begin
        if (pg[i][b]) begin
          logic [PW-1:0] pos;
          pos = PW'(i * 8 + b);
          for (int k = 0; k < PW; k++) begin
            if (pos[k]) p[k] = ~p[k]; else n[k] = ~n[k];
          end
        end
      end
    end
    return {n, p};
  endfunction

  task automatic drive(input logic c, input logic a, input logic d, input logic [7:0] v);
    @(negedge clk);
    cmd_stb = c; addr_stb = a; data_stb = d; bus_byte = v;
    @(negedge clk);
    cmd_stb = 0; addr_stb = 0; data_stb = 0;
  endtask

  task automatic read_page(input logic [23:0] cv, input bit clash);
    drive(1, 0, 0, 8'h00);
    for (int i = 0; i < ADDRC; i++) drive(0, 1, 0, 8'h11);
    drive(0, 0, 1, 8'hC3);            // before confirm: must be ignored (R3)
    drive(1, 0, 0, 8'h30);
    for (int i = 0; i < MAIN; i++) drive(0, 0, 1, pg[i]);
    for (int j = 0; j < CB - 1; j++) drive(0, 0, 1, cv[j*8 +: 8]);
    @(negedge clk);
    data_stb = 1; bus_byte = cv[23:16];
    @(negedge clk);
    data_stb = 0;
    if (clash) begin cmd_stb = 1; bus_byte = 8'h00; end
    @(negedge clk);
    cmd_stb = 0;
    repeat (3) @(negedge clk);
  endtask

  task automatic finish_up();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired: actual hung, expected completion");
    finish_up();
  end

  initial begin
    logic [2*PW-1:0] gold, cur;
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    expect_now("R1 reset", '0, 0, 4'b0000, 0, 0);

    for (int i = 0; i < MAIN; i++) pg[i] = 8'((i * 37 + 11) ^ (i >> 3));
    gold = model();

    // program page with a stray beat before the address cycles
    drive(1, 0, 0, 8'h80);
    drive(0, 0, 1, 8'hFF);
    for (int i = 0; i < ADDRC; i++) drive(0, 1, 0, 8'h22);
    for (int i = 0; i < MAIN; i++) drive(0, 0, 1, pg[i]);
    @(negedge clk);
    expect_now("R2 R4 program code", gold, 0, 4'b0000, 0, 0);

    drive(0, 0, 1, 8'h5A); drive(1, 0, 0, 8'h70); drive(0, 0, 1, 8'hA5);
    expect_now("R5 frozen after main area", gold, 0, 4'b0000, 0, 0);

    read_page(24'(gold), 0);
    expect_now("R3 R6 R7 clean read", gold, 1, 4'b1000, 0, 0);

    pg[77][5] = ~pg[77][5]; cur = model();
    read_page(24'(gold), 0);
    expect_now("R8 correctable 77/5", cur, 1, 4'b0100, 8'd77, 3'd5);
    pg[77][5] = ~pg[77][5];

    pg[0][0] = ~pg[0][0]; cur = model();
    read_page(24'(gold), 0);
    expect_now("R8 correctable 0/0", cur, 1, 4'b0100, 8'd0, 3'd0);
    pg[0][0] = ~pg[0][0];

    pg[255][7] = ~pg[255][7]; cur = model();
    read_page(24'(gold), 0);
    expect_now("R8 correctable 255/7", cur, 1, 4'b0100, 8'd255, 3'd7);
    pg[255][7] = ~pg[255][7];

    read_page(24'(gold) ^ 24'h000008, 0);
    expect_now("R9 stored code bit error", gold, 1, 4'b0010, 0, 0);

    pg[10][1] = ~pg[10][1]; pg[200][6] = ~pg[200][6]; cur = model();
    read_page(24'(gold), 0);
    expect_now("R10 double data error", cur, 1, 4'b0001, 0, 0);

    drive(1, 0, 0, 8'h70); drive(0, 1, 0, 8'h33);
    drive(0, 0, 1, 8'h99); drive(1, 0, 0, 8'h30);
    expect_now("R12 result held", cur, 1, 4'b0001, 0, 0);
    pg[10][1] = ~pg[10][1]; pg[200][6] = ~pg[200][6];

    read_page(24'(gold), 1);
    expect_now("R11 clear beats publish", '0, 0, 4'b0000, 0, 0);

    drive(1, 0, 0, 8'h80);
    drive(0, 0, 1, 8'h80);
    for (int i = 0; i < ADDRC; i++) drive(0, 1, 0, 8'h44);
    @(negedge clk);
    expect_now("R2 cleared after 80h", '0, 0, 4'b0000, 0, 0);
    drive(0, 0, 1, 8'h01);
    expect_now("R2 R4 first beat only", {{PW{1'b1}}, {PW{1'b0}}}, 0, 4'b0000, 0, 0);

    finish_up();
  end
endmodule